// File: doc/BRIEF.md
# Page Write-Protection and Password Gate

This block is the access-control stage between a command decoder and a small register-held model of a paged nonvolatile memory. The memory holds a set of 4-byte user pages (eight by default), a configuration page at index N and a password page at index N+1. Every decoded command arrives with a page index and a data word. The gate decides whether that command may run. It applies the permitted ones to the stored pages, the lock bits and a password-verified latch. It answers with a one-cycle grant or deny pulse, read data, and an abort pulse.

Protection has three layers. The first is a per-page user lock mask that can only gain bits. The second is a pair of directly written lock bits, one guarding the configuration page and one guarding the password. The third is a password latch that must be set before anything runs once password mode is switched on. A failed password check drops the latch, which is the power-up state of the gate. Lock bits and page contents are nonvolatile in intent and survive an abort.

Top module: `pwgate_top`

## Requirements
- R1: With password mode on and the latch clear, every command other than check-password is refused. This covers read, write, write-lock, write-password and write-config.
- R2: A check-password command whose data equals the stored password is granted and sets the latch. From the next command on, reads, writes and lock updates are permitted subject to the lock bits.
- R3: A check-password command with a mismatching word has these effects. It raises deny and abort together, one cycle later. It clears the latch. It leaves pages and lock bits unchanged.
- R4: A read of the password page (index N+1), or of any index above it, is always refused and returns rd_data of zero.
- R5: User lock bit i guards user page i. The lock bits are loaded from cmd_data[N-1:0] of a write-lock command. A page write is refused while its bit is 1 and allowed while it is 0.
- R6: Write-lock ORs cmd_data[N-1:0] into the user lock mask, so a user lock bit never returns to 0.
- R7: A write to a locked user page is refused even while the latch is set.
- R8: The configuration lock bit is taken from cmd_data[N] of a write-lock. Once it is 1, write-config is refused and neither the configuration lock bit nor the password lock bit changes again.
- R9: The password lock bit is taken from cmd_data[N+1] of a write-lock. While it is 1, write-password is refused. While the configuration lock is 0, this bit takes the written value and can return to 0.
- R10: A set configuration lock does not stop write-lock from adding bits to the user lock mask.
- R11: Each command gives exactly one of grant or deny, as a single-cycle pulse in the cycle after cmd_valid. Neither pulse appears without a command. All outputs are zero out of reset. A refused command leaves all stored state unchanged. Opcodes 6 and 7 are always refused.
- R12: Password mode is configuration word bit 0. While it is 0, the latch counts as set.
- R13: A granted read of user page p returns that page's word on rd_data in the cycle after the command. A granted read of page N returns the configuration word. Every other command leaves rd_data at zero.
- R14: cmd_op encodes the commands as follows: 0 is read, 1 is write-page, 2 is write-lock, 3 is check-password, 4 is write-password and 5 is write-config. Write-page only targets indices 0 to N-1 and is refused for any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores power-up state and initial memory |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command opcode (R14) |
| cmd_page | input | $clog2(N+2) | Page index |
| cmd_data | input | WORD_W | Write data, lock mask or password candidate |
| grant | output | 1 | Command accepted, one cycle after it |
| deny | output | 1 | Command refused, one cycle after it |
| abort | output | 1 | Password mismatch; latch returned to power-up state |
| rd_data | output | WORD_W | Read word of a granted read, else zero |

## Verification
The bench sweeps every user page through writes and reads under several lock masks. It then tries each command in each protection state. A gate that ORs the configuration and password lock bits would fail to let the password lock fall while the configuration lock is clear. A gate that did not freeze them would let the password lock fall after the configuration lock is set. A design that skipped the lock check under a set latch would grant writes to locked pages. A design that forgot to clear the latch on a bad password would keep granting reads after an abort. Reads at the password index and above must stay at zero, and after reserved opcodes a read-back shows that nothing moved.

// File: rtl/pwgate_pkg.sv
package pwgate_pkg;
   typedef enum logic [2:0] {
      OP_READ   = 3'd0,
      OP_WRITE  = 3'd1,
      OP_WRLOCK = 3'd2,
      OP_CHKPW  = 3'd3,
      OP_WRPW   = 3'd4,
      OP_WRCFG  = 3'd5,
      OP_RSV6   = 3'd6,
      OP_RSV7   = 3'd7
   } op_e;

   localparam int CFG_PWMODE_BIT = 0;
endpackage

// File: rtl/pwgate_locks.sv
module pwgate_locks #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd_en,
   input  logic [N+1:0] upd_data,
   output logic [N-1:0] user_lock,
   output logic         cfg_lock,
   output logic         pw_lock
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         user_lock <= '0;
         cfg_lock  <= 1'b0;
         pw_lock   <= 1'b0;
      end else if (upd_en) begin
         user_lock <= user_lock | upd_data[N-1:0];
         if (!cfg_lock) begin
            cfg_lock <= upd_data[N];
            pw_lock  <= upd_data[N+1];
         end
      end
   end

   // R6: no user lock bit ever falls
   a_r6_user_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((user_lock & $past(user_lock)) == $past(user_lock)));

   // R8: a set configuration lock freezes both page-lock bits
   a_r8_locks_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_lock)) |-> (cfg_lock && $stable(pw_lock)));
endmodule

// File: rtl/pwgate_auth.sv
module pwgate_auth #(
   parameter bit PW_FEATURE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic pw_mode_i,
   output logic authorized_o
);
   generate
      if (PW_FEATURE) begin : g_latch
         logic latch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     latch_q <= 1'b0;
            else if (clr_i) latch_q <= 1'b0;
            else if (set_i) latch_q <= 1'b1;
         end
         assign authorized_o = latch_q | ~pw_mode_i;

         // R3: a mismatch returns the latch to its power-up value
         a_r3_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> !latch_q);
         // R2: a matching check sets the latch
         a_r2_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i && !clr_i) |=> latch_q);
      end else begin : g_open
         logic unused_w;
         assign unused_w     = set_i ^ clr_i ^ pw_mode_i ^ clk ^ rst_n;
         assign authorized_o = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pwgate_store.sv
module pwgate_store #(
   parameter int              N       = 8,
   parameter int              WORD_W  = 32,
   parameter logic [WORD_W-1:0] PW_INIT = '0,
   localparam int             UIW     = $clog2(N),
   localparam int             PAW     = $clog2(N + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_user_en,
   input  logic [UIW-1:0]    wr_user_idx,
   input  logic              wr_cfg_en,
   input  logic              wr_pw_en,
   input  logic [WORD_W-1:0] wdata,
   input  logic [PAW-1:0]    rd_idx,
   output logic [WORD_W-1:0] cfg_word,
   output logic [WORD_W-1:0] pw_word,
   output logic [WORD_W-1:0] rd_word
);
   localparam logic [PAW-1:0] PG_CFG = PAW'(N);

   logic [WORD_W-1:0] page_q [N];

   generate
      for (genvar g = 0; g < N; g++) begin : g_page
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               page_q[g] <= '0;
            else if (wr_user_en && (wr_user_idx == UIW'(g)))
               page_q[g] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_word <= '0;
         pw_word  <= PW_INIT;
      end else begin
         if (wr_cfg_en) cfg_word <= wdata;
         if (wr_pw_en)  pw_word  <= wdata;
      end
   end

   always_comb begin
      if (rd_idx < PG_CFG)       rd_word = page_q[rd_idx[UIW-1:0]];
      else if (rd_idx == PG_CFG) rd_word = cfg_word;
      else                       rd_word = '0;
   end
endmodule

// File: rtl/pwgate_top.sv
module pwgate_top
   import pwgate_pkg::*;
#(
   parameter int                N          = 8,
   parameter int                WORD_W     = 32,
   parameter bit                PW_FEATURE = 1'b1,
   parameter logic [WORD_W-1:0] PW_INIT    = WORD_W'(32'hC0DE_5EED),
   localparam int               UIW        = $clog2(N),
   localparam int               PAW        = $clog2(N + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [PAW-1:0]    cmd_page,
   input  logic [WORD_W-1:0] cmd_data,
   output logic              grant,
   output logic              deny,
   output logic              abort,
   output logic [WORD_W-1:0] rd_data
);
   localparam logic [PAW-1:0] PG_CFG = PAW'(N);
   localparam logic [PAW-1:0] PG_PW  = PAW'(N + 1);

   generate
      if (N < 2)            begin : g_bad_n $error("pwgate_top: N must be at least 2"); end
      if (WORD_W < N + 2)   begin : g_bad_w $error("pwgate_top: WORD_W must hold N+2 lock bits"); end
   endgenerate

   op_e               op;
   logic              is_user, page_locked, pw_match, authorized, ok;
   logic              accept, refuse, bad_pw;
   logic [N-1:0]      user_lock;
   logic              cfg_lock, pw_lock;
   logic [WORD_W-1:0] cfg_word, pw_word, rd_word;

   assign op          = op_e'(cmd_op);
   assign is_user     = cmd_page < PG_CFG;
   assign page_locked = is_user ? user_lock[cmd_page[UIW-1:0]] : 1'b1;
   assign pw_match    = (cmd_data == pw_word);

   always_comb begin
      unique case (op)
         OP_READ:   ok = authorized & (is_user | (cmd_page == PG_CFG));
         OP_WRITE:  ok = authorized & is_user & ~page_locked;
         OP_WRLOCK: ok = authorized;
         OP_CHKPW:  ok = pw_match;
         OP_WRPW:   ok = authorized & ~pw_lock;
         OP_WRCFG:  ok = authorized & ~cfg_lock;
         default:   ok = 1'b0;
      endcase
   end

   assign accept = cmd_valid & ok;
   assign refuse = cmd_valid & ~ok;
   assign bad_pw = cmd_valid & (op == OP_CHKPW) & ~pw_match;

   pwgate_locks #(.N(N)) locks_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (accept && (op == OP_WRLOCK)),
      .upd_data  (cmd_data[N+1:0]),
      .user_lock (user_lock),
      .cfg_lock  (cfg_lock),
      .pw_lock   (pw_lock)
   );

   pwgate_auth #(.PW_FEATURE(PW_FEATURE)) auth_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_i        (accept && (op == OP_CHKPW)),
      .clr_i        (bad_pw),
      .pw_mode_i    (cfg_word[CFG_PWMODE_BIT]),
      .authorized_o (authorized)
   );

   pwgate_store #(.N(N), .WORD_W(WORD_W), .PW_INIT(PW_INIT)) store_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_user_en  (accept && (op == OP_WRITE)),
      .wr_user_idx (cmd_page[UIW-1:0]),
      .wr_cfg_en   (accept && (op == OP_WRCFG)),
      .wr_pw_en    (accept && (op == OP_WRPW)),
      .wdata       (cmd_data),
      .rd_idx      (cmd_page),
      .cfg_word    (cfg_word),
      .pw_word     (pw_word),
      .rd_word     (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant   <= 1'b0;
         deny    <= 1'b0;
         abort   <= 1'b0;
         rd_data <= '0;
      end else begin
         grant   <= accept;
         deny    <= refuse;
         abort   <= bad_pw;
         rd_data <= (accept && (op == OP_READ)) ? rd_word : '0;
      end
   end

   // R1: locked out until the password latch is set
   a_r1_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cfg_word[CFG_PWMODE_BIT] && !authorized && (op != OP_CHKPW)) |=> deny);
   // R4: the password page never appears on rd_data
   a_r4_pw_unreadable: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (op == OP_READ) && (cmd_page >= PG_PW)) |=> (deny && (rd_data == '0)));
   // R7: a locked page is never written, latch or not
   a_r7_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (op == OP_WRITE) && is_user && user_lock[cmd_page[UIW-1:0]]) |=> !grant);
   // R11: grant and deny never together, never without a command
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant, deny}));
   a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(cmd_valid)) |-> (!grant && !deny));
   // R3: an abort is always a refusal
   a_r3_abort_denies: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> deny);
endmodule

// File: tb/pwgate_top_tb_top.sv
`timescale 1ns/1ps
module pwgate_top_tb_top;
   localparam int          N   = 8;
   localparam int          W   = 32;
   localparam logic [31:0] PW0 = 32'hC0DE_5EED;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [3:0]  cmd_page = '0;
   logic [31:0] cmd_data = '0;
   logic        grant, deny, abort;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;

   // bench-side model of stored state
   logic [31:0] m_page [N];
   logic [31:0] m_cfg, m_pw;
   logic [7:0]  m_ul;
   logic        m_cl, m_pl, m_latch;

   always #2.5 clk = ~clk;

   pwgate_top dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_page(cmd_page), .cmd_data(cmd_data), .grant(grant), .deny(deny),
      .abort(abort), .rd_data(rd_data)
   );

   task automatic check(input string tag, input logic g, input logic d, input logic a,
                        input logic [31:0] r);
      checks++;
      if (grant !== g || deny !== d || abort !== a || rd_data !== r) begin
         errors++;
         $display("FAIL %s: got g%b d%b a%b rd=%h, expected g%b d%b a%b rd=%h",
                  tag, grant, deny, abort, rd_data, g, d, a, r);
      end
   endtask

   task automatic run(input logic [2:0] op, input logic [3:0] pg, input logic [31:0] d,
                      input string tag);
      logic auth, isu, ok, bad;
      logic [31:0] er;
      auth = m_latch | ~m_cfg[0];
      isu  = (pg < 4'(N));
      case (op)
         3'd0: ok = auth & (isu | (pg == 4'(N)));
         3'd1: ok = auth & isu & (isu ? ~m_ul[pg[2:0]] : 1'b0);
         3'd2: ok = auth;
         3'd3: ok = (d == m_pw);
         3'd4: ok = auth & ~m_pl;
         3'd5: ok = auth & ~m_cl;
         default: ok = 1'b0;
      endcase
      bad = (op == 3'd3) && (d != m_pw);
      er  = (ok && op == 3'd0) ? (isu ? m_page[pg[2:0]] : m_cfg) : 32'h0;
      if (ok) begin
         case (op)
            3'd1: m_page[pg[2:0]] = d;
            3'd2: begin
               m_ul = m_ul | d[7:0];
               if (!m_cl) begin m_cl = d[8]; m_pl = d[9]; end
            end
            3'd3: m_latch = 1'b1;
            3'd4: m_pw = d;
            3'd5: m_cfg = d;
            default: ;
         endcase
      end
      if (bad) m_latch = 1'b0;
      @(negedge clk);
      cmd_op = op; cmd_page = pg; cmd_data = d; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(tag, ok, ~ok, bad, er);
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) m_page[i] = '0;
      m_cfg = '0; m_pw = PW0; m_ul = '0; m_cl = 0; m_pl = 0; m_latch = 0;
      repeat (3) @(negedge clk);
      check("R11 reset outputs", 1'b0, 1'b0, 1'b0, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 idle after reset", 1'b0, 1'b0, 1'b0, 32'h0);

      // password mode off: everything open (R12), write/read sweep (R13)
      for (int p = 0; p < N; p++) run(3'd1, 4'(p), 32'h1000_0000 + 32'(p) * 32'h0101, "R12 write open");
      for (int p = 0; p < N; p++) run(3'd0, 4'(p), 32'h0, "R13 read back");
      run(3'd0, 4'd8, 32'h0, "R13 read config page");
      for (int p = 9; p < 16; p++) run(3'd0, 4'(p), 32'h0, "R4 read pw/out-of-range");
      for (int p = 8; p < 16; p++) run(3'd1, 4'(p), 32'hDEAD_BEEF, "R14 write beyond user pages");
      run(3'd6, 4'd3, 32'hFFFF_FFFF, "R11 reserved op 6");
      run(3'd7, 4'd3, 32'hFFFF_FFFF, "R11 reserved op 7");
      run(3'd0, 4'd3, 32'h0, "R11 state unchanged after refusal");

      // enable password mode
      run(3'd5, 4'd8, 32'h0000_0001, "R12 write config open");
      run(3'd0, 4'd0, 32'h0, "R1 read refused");
      run(3'd1, 4'd1, 32'h1111_1111, "R1 write refused");
      run(3'd2, 4'd0, 32'h0000_00FF, "R1 lock refused");
      run(3'd4, 4'd9, 32'h1234_5678, "R1 wrpw refused");
      run(3'd5, 4'd8, 32'h0, "R1 wrcfg refused");
      run(3'd3, 4'd9, PW0 ^ 32'h1, "R3 wrong password aborts");
      run(3'd0, 4'd2, 32'h0, "R3 still refused after abort");
      run(3'd3, 4'd9, PW0, "R2 correct password");
      run(3'd0, 4'd5, 32'h0, "R2 read after latch");
      run(3'd0, 4'd9, 32'h0, "R4 pw page with latch");

      // user locks
      run(3'd2, 4'd0, 32'h0000_0005, "R5 set user locks 0,2");
      for (int p = 0; p < N; p++) run(3'd1, 4'(p), 32'hA000_0000 | 32'(p), "R7 locked write sweep");
      for (int p = 0; p < N; p++) run(3'd0, 4'(p), 32'h0, "R5 read after lock sweep");
      run(3'd2, 4'd0, 32'h0000_0000, "R6 zero mask lock");
      run(3'd1, 4'd0, 32'h5555_5555, "R6 page 0 stays locked");
      run(3'd1, 4'd2, 32'h5555_5555, "R6 page 2 stays locked");
      run(3'd0, 4'd0, 32'h0, "R6 page 0 content kept");

      // abort again
      run(3'd3, 4'd9, 32'h0, "R3 second wrong password");
      run(3'd1, 4'd1, 32'h7777_7777, "R3 write refused after abort");
      run(3'd3, 4'd9, PW0, "R2 re-verify");
      run(3'd0, 4'd1, 32'h0, "R3 page 1 untouched");

      // password lock
      run(3'd4, 4'd9, 32'hFEED_0001, "R9 write password");
      run(3'd3, 4'd9, PW0, "R9 old password now wrong");
      run(3'd3, 4'd9, 32'hFEED_0001, "R9 new password accepted");
      run(3'd2, 4'd0, 32'h0000_0200, "R9 set pw lock");
      run(3'd4, 4'd9, 32'hFEED_0002, "R9 wrpw blocked");
      run(3'd2, 4'd0, 32'h0000_0000, "R9 clear pw lock (not OR)");
      run(3'd4, 4'd9, 32'hFEED_0003, "R9 wrpw allowed again");

      // config lock
      run(3'd2, 4'd0, 32'h0000_0300, "R8 set cfg and pw locks");
      run(3'd5, 4'd8, 32'h0000_0000, "R8 wrcfg blocked");
      run(3'd2, 4'd0, 32'h0000_0000, "R8 try clearing locks");
      run(3'd4, 4'd9, 32'hFEED_0004, "R8 pw lock frozen");
      run(3'd5, 4'd8, 32'h0000_0000, "R8 cfg lock frozen");
      run(3'd0, 4'd8, 32'h0, "R8 config word kept");
      run(3'd2, 4'd0, 32'h0000_0002, "R10 user lock under cfg lock");
      run(3'd1, 4'd1, 32'h2222_2222, "R10 page 1 now locked");
      run(3'd1, 4'd3, 32'h3333_3333, "R10 page 3 still open");
      run(3'd0, 4'd3, 32'h0, "R13 read page 3");
      run(3'd3, 4'd9, 32'hFEED_0003, "R2 final password check");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule